// File: doc/BRIEF.md
# Round-Robin Four-Position SPI Master with Companion Slave

The block is a full-duplex SPI master that visits four slave-select positions in a fixed cycle. Each visit is one 8-bit exchange in SPI mode 0, MSB first. A constant byte goes out on MOSI while the byte coming back on MISO is shifted in. At the end of every exchange the master shows the received byte, gives a one-cycle completion pulse, and updates a flag that tells whether the byte equals a fixed expected value. Every position gets the same slot length, so with one slave fitted the flag is high for one slot out of four.

A companion slave module goes on any select line. It returns its own constant byte during the same exchange. It captures the byte from the master and compares it with its own expected value. While its select line is high it leaves MISO undriven, ignores SCLK and holds its bit counters cleared.

SCLK is the system clock divided by an even parameter. Each select line goes low half an SCLK period before the first rising edge and goes high again after the last falling edge. All lines then stay high for one full SCLK period before the next position is selected.

Top module: `spi_rr_master`

## Requirements
- R1: While reset is asserted, ss_n is 4'b1111, sclk is 0, done is 0, match is 0 and rx_data is 0.
- R2: Each exchange has exactly 8 rising SCLK edges. SCLK idles low. MOSI carries TX_BYTE MSB first and is stable while SCLK is high.
- R3: Exchanges visit positions 0, 1, 2, 3 and then wrap to 0. Exactly one select line is low during an exchange, and position 3 drives ss_n = 4'b0111.
- R4: A select line is low for at least CLK_DIV/2 system cycles before the first rising SCLK edge. SCLK is low when the line rises, and SCLK never pulses while all lines are high.
- R5: Between two exchanges all select lines stay high for at least CLK_DIV system cycles.
- R6: done is high for exactly one cycle per exchange, in the cycle in which the select line returns high. At that point rx_data holds the 8 bits sampled from MISO on the rising edges, MSB first.
- R7: match equals (rx_data == KNOWN_BYTE). Both match and rx_data change only when done is high.
- R8: A position whose MISO line idles high (byte 8'hFF) never counts as a match. With only position 3 answering KNOWN_BYTE, match is high for exactly one quarter of each full round.
- R9: With enable low, no select line goes low. Dropping enable during an exchange lets that exchange finish with its done pulse, and then no further exchange starts.
- R10: The slave captures the 8 MOSI bits (MSB first) of a selected exchange into its rx_data. It sets its match to (rx_data == its KNOWN_BYTE) and returns its TX_BYTE MSB first on MISO.
- R11: A high select line clears the slave's bit counters and makes it ignore SCLK. An aborted partial exchange or SCLK pulses while deselected leave its rx_data unchanged, and the next full exchange is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new exchanges to start |
| sclk | output | 1 | Serial clock, mode 0 (idle low) |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the selected slave |
| ss_n | output | NUM_SS | Active-low select lines, one per position |
| rx_data | output | DATA_W | Byte from the most recent exchange |
| done | output | 1 | One-cycle pulse at the end of each exchange |
| match | output | 1 | Most recent received byte equals KNOWN_BYTE |

## Verification
The bench runs the master against a real slave on position 3, with a modelled slave on positions 0 to 2. The model feeds all 256 byte values through those positions in turn. A shift register that dropped or reordered a bit, or a compare against the wrong constant, would give a wrong rx_data or a false match on some of these bytes. A first phase with idle-high lines on the empty positions measures the fraction of each round for which match is high. A design whose flag leaked between exchanges, or that rotated positions unevenly, would miss the exact one-quarter ratio. The select setup time, the gap between exchanges and the stop on a dropped enable are counted in system cycles. A design that released the select early, skipped the gap, or started one more exchange would fail those counts. A separately driven slave is cut off after five bits and then clocked while deselected. A slave that kept its counters across deselection would then receive the next byte shifted.

// File: rtl/spi_rr_pkg.sv
package spi_rr_pkg;

   // Half-SCLK periods in one slot: setup, 2*W edge halves, two gap halves.
   function automatic int unsigned slot_halves(int unsigned w);
      return 2 * w + 3;
   endfunction

   function automatic int unsigned hp_width(int unsigned w);
      return $clog2(slot_halves(w));
   endfunction

   function automatic int unsigned cnt_width(int unsigned half);
      return (half > 1) ? $clog2(half) : 1;
   endfunction

   function automatic int unsigned pos_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/spi_rr_timer.sv
module spi_rr_timer
   import spi_rr_pkg::*;
#(
   parameter int unsigned NUM_SS  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CLK_DIV = 4,
   localparam int unsigned HALF   = CLK_DIV / 2,
   localparam int unsigned HPW    = hp_width(DATA_W),
   localparam int unsigned CNTW   = cnt_width(HALF),
   localparam int unsigned POSW   = pos_width(NUM_SS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   output logic            running,
   output logic [HPW-1:0]  hp_idx,
   output logic            hp_first,
   output logic            half_end,
   output logic [POSW-1:0] pos
);
   localparam logic [HPW-1:0]  HP_LAST  = HPW'(slot_halves(DATA_W) - 1);
   localparam logic [CNTW-1:0] CNT_END  = CNTW'(HALF - 1);
   localparam logic [POSW-1:0] POS_LAST = POSW'(NUM_SS - 1);

   logic [CNTW-1:0] hp_cnt;

   assign hp_first = (hp_cnt == '0);
   assign half_end = (hp_cnt == CNT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         hp_cnt  <= '0;
         hp_idx  <= '0;
         pos     <= '0;
      end else if (!running) begin
         hp_cnt <= '0;
         hp_idx <= '0;
         if (enable) running <= 1'b1;
      end else if (half_end) begin
         hp_cnt <= '0;
         if (hp_idx == HP_LAST) begin
            hp_idx  <= '0;
            pos     <= (pos == POS_LAST) ? '0 : pos + 1'b1;
            running <= enable;
         end else begin
            hp_idx <= hp_idx + 1'b1;
         end
      end else begin
         hp_cnt <= hp_cnt + 1'b1;
      end
   end

   // Slot index never runs past the last gap half.
   assert_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hp_idx <= HP_LAST);

endmodule

// File: rtl/spi_rr_shifter.sv
module spi_rr_shifter
   import spi_rr_pkg::*;
#(
   parameter int unsigned        DATA_W     = 8,
   parameter logic [DATA_W-1:0]  TX_BYTE    = 8'hBB,
   parameter logic [DATA_W-1:0]  KNOWN_BYTE = 8'h5A,
   localparam int unsigned       HPW        = hp_width(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic [HPW-1:0]    hp_idx,
   input  logic              hp_first,
   input  logic              half_end,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_data,
   output logic              done,
   output logic              match
);
   localparam logic [HPW-1:0] HP_EDGE_END  = HPW'(2 * DATA_W);
   localparam logic [HPW-1:0] HP_SHIFT_END = HPW'(2 * DATA_W - 1);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic              take_bit;
   logic              next_bit;
   logic              finish;

   assign take_bit = running && hp_first && hp_idx[0] && (hp_idx < HP_EDGE_END);
   assign next_bit = running && half_end && hp_idx[0] && (hp_idx < HP_SHIFT_END);
   assign finish   = running && half_end && (hp_idx == HP_EDGE_END);
   assign mosi     = tx_sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= TX_BYTE;
      end else if (!running || hp_idx > HP_EDGE_END) begin
         tx_sh <= TX_BYTE;
      end else if (next_bit) begin
         tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh <= '0;
      end else if (take_bit) begin
         rx_sh <= {rx_sh[DATA_W-2:0], miso};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         match   <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= finish;
         if (finish) begin
            rx_data <= rx_sh;
            match   <= (rx_sh == KNOWN_BYTE);
         end
      end
   end

   // The result flag tracks the stored byte after each update.
   assert_match_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (match == (rx_data == KNOWN_BYTE)));

endmodule

// File: rtl/spi_rr_lines.sv
module spi_rr_lines
   import spi_rr_pkg::*;
#(
   parameter int unsigned NUM_SS = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned HPW   = hp_width(DATA_W),
   localparam int unsigned POSW  = pos_width(NUM_SS)
) (
   input  logic              running,
   input  logic [HPW-1:0]    hp_idx,
   input  logic [POSW-1:0]   pos,
   output logic              sclk,
   output logic [NUM_SS-1:0] ss_n
);
   localparam logic [HPW-1:0] HP_EDGE_END = HPW'(2 * DATA_W);

   logic sel_on;

   assign sel_on = running && (hp_idx <= HP_EDGE_END);
   assign sclk   = running && hp_idx[0] && (hp_idx < HP_EDGE_END);

   for (genvar i = 0; i < NUM_SS; i++) begin : g_line
      assign ss_n[i] = !(sel_on && (pos == POSW'(i)));
   end

endmodule

// File: rtl/spi_rr_slave.sv
module spi_rr_slave #(
   parameter int unsigned       DATA_W     = 8,
   parameter logic [DATA_W-1:0] TX_BYTE    = 8'h5A,
   parameter logic [DATA_W-1:0] KNOWN_BYTE = 8'hBB,
   localparam int unsigned      CW         = $clog2(DATA_W)
) (
   input  logic              sclk,
   input  logic              mosi,
   output logic              miso,
   input  logic              ss_n,
   output logic [DATA_W-1:0] rx_data,
   output logic              match
);
   localparam logic [CW-1:0] CNT_END = CW'(DATA_W - 1);

   logic [CW-1:0]     in_cnt;
   logic [CW-1:0]     out_cnt;
   logic [DATA_W-2:0] in_sh;
   logic [CW-1:0]     bit_sel;

   if (DATA_W < 4) begin : g_bad_width
      $error("spi_rr_slave: DATA_W must be at least 4");
   end

   always_ff @(posedge sclk or posedge ss_n) begin
      if (ss_n) begin
         in_cnt <= '0;
         in_sh  <= '0;
      end else begin
         in_sh  <= {in_sh[DATA_W-3:0], mosi};
         in_cnt <= (in_cnt == CNT_END) ? '0 : in_cnt + 1'b1;
      end
   end

   // Counter held at zero while deselected, so stray edges never complete a byte.
   always_ff @(posedge sclk) begin
      if (in_cnt == CNT_END) begin
         rx_data <= {in_sh, mosi};
         match   <= ({in_sh, mosi} == KNOWN_BYTE);
      end
   end

   always_ff @(negedge sclk or posedge ss_n) begin
      if (ss_n) out_cnt <= '0;
      else      out_cnt <= (out_cnt == CNT_END) ? '0 : out_cnt + 1'b1;
   end

   assign bit_sel = CNT_END - out_cnt;
   assign miso    = ss_n ? 1'bz : TX_BYTE[bit_sel];

endmodule

// File: rtl/spi_rr_master.sv
module spi_rr_master
   import spi_rr_pkg::*;
#(
   parameter int unsigned       NUM_SS     = 4,
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       CLK_DIV    = 4,
   parameter logic [DATA_W-1:0] TX_BYTE    = 8'hBB,
   parameter logic [DATA_W-1:0] KNOWN_BYTE = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n,
   output logic [DATA_W-1:0] rx_data,
   output logic              done,
   output logic              match
);
   localparam int unsigned HPW  = hp_width(DATA_W);
   localparam int unsigned POSW = pos_width(NUM_SS);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("spi_rr_master: CLK_DIV must be even and at least 2");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("spi_rr_master: DATA_W must be at least 4");
   end
   if (NUM_SS < 2) begin : g_bad_count
      $error("spi_rr_master: NUM_SS must be at least 2");
   end

   logic            running;
   logic [HPW-1:0]  hp_idx;
   logic            hp_first;
   logic            half_end;
   logic [POSW-1:0] pos;

   spi_rr_timer #(
      .NUM_SS (NUM_SS),
      .DATA_W (DATA_W),
      .CLK_DIV(CLK_DIV)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .running (running),
      .hp_idx  (hp_idx),
      .hp_first(hp_first),
      .half_end(half_end),
      .pos     (pos)
   );

   spi_rr_shifter #(
      .DATA_W    (DATA_W),
      .TX_BYTE   (TX_BYTE),
      .KNOWN_BYTE(KNOWN_BYTE)
   ) u_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .running (running),
      .hp_idx  (hp_idx),
      .hp_first(hp_first),
      .half_end(half_end),
      .miso    (miso),
      .mosi    (mosi),
      .rx_data (rx_data),
      .done    (done),
      .match   (match)
   );

   spi_rr_lines #(
      .NUM_SS(NUM_SS),
      .DATA_W(DATA_W)
   ) u_lines (
      .running(running),
      .hp_idx (hp_idx),
      .pos    (pos),
      .sclk   (sclk),
      .ss_n   (ss_n)
   );

   assert_one_cold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ss_n) <= 1);

   assert_sclk_needs_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> (ss_n != {NUM_SS{1'b1}}));

   assert_mosi_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ss_n == {NUM_SS{1'b1}}));

   assert_match_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(match) && $stable(rx_data)));

endmodule

// File: tb/spi_rr_master_bench.sv
module spi_rr_master_bench;
   localparam int W    = 8;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam logic [7:0] M_TX    = 8'hBB;
   localparam logic [7:0] M_KNOWN = 8'h5A;
   localparam logic [7:0] S_TX    = 8'h5A;
   localparam logic [7:0] S_KNOWN = 8'hBB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   always #2.5 clk = ~clk;

   wire       sclk, mosi, done, match;
   wire [3:0] ss_n;
   wire [7:0] rx_data;
   wire       slv_miso, slv_match;
   wire [7:0] slv_rx;

   logic       model_en = 1'b0;
   logic [7:0] model_byte = 8'hFF;
   logic [2:0] model_idx = 3'd0;
   wire        all_hi    = &ss_n;
   wire        model_bit = model_en ? model_byte[3'd7 - model_idx] : 1'b1;
   wire        miso_in   = !ss_n[3] ? slv_miso : model_bit;

   always @(negedge sclk or posedge all_hi) begin
      if (all_hi) model_idx <= 3'd0;
      else        model_idx <= model_idx + 3'd1;
   end

   spi_rr_master u_spi_rr_master (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sclk(sclk), .mosi(mosi),
      .miso(miso_in), .ss_n(ss_n), .rx_data(rx_data), .done(done), .match(match)
   );

   spi_rr_slave #(.DATA_W(8), .TX_BYTE(S_TX), .KNOWN_BYTE(S_KNOWN)) u_fitted (
      .sclk(sclk), .mosi(mosi), .miso(slv_miso), .ss_n(ss_n[3]),
      .rx_data(slv_rx), .match(slv_match)
   );

   logic t_sclk = 1'b0, t_mosi = 1'b0, t_ss = 1'b1;
   wire  t_miso, t_match;
   wire [7:0] t_rx;
   spi_rr_slave #(.DATA_W(8), .TX_BYTE(S_TX), .KNOWN_BYTE(S_KNOWN)) u_lone (
      .sclk(t_sclk), .mosi(t_mosi), .miso(t_miso), .ss_n(t_ss),
      .rx_data(t_rx), .match(t_match)
   );

   int tests = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Monitor state
   int  rises = 0, pre_cnt = 0, gap_cnt = 0, cur_pos = 0, exp_pos = 0;
   int  done_total = 0, fall_total = 0, sweep_v = 0, hi_cnt = 0, tot_cnt = 0;
   bit  prev_sclk = 0, prev_hi = 1, prev_done = 0, seen_xfer = 0, measuring = 0;
   bit  want_sweep = 0, last_match = 0;
   logic [7:0] mosi_byte = 8'h00, last_rx = 8'h00;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done && cur_pos == 0 && !model_en) begin
            if (measuring) chk(hi_cnt * 4 == tot_cnt, "R8", "quarter duty", hi_cnt, tot_cnt / 4);
            measuring = 1; hi_cnt = 0; tot_cnt = 0;
         end
         if (model_en) measuring = 0;
         if (measuring) begin tot_cnt++; if (match) hi_cnt++; end

         if (!all_hi) begin
            if (prev_hi) begin
               fall_total++;
               cur_pos = 0;
               for (int i = 0; i < 4; i++) if (!ss_n[i]) cur_pos = i;
               chk($countones(~ss_n) == 1, "R3", "one line low", ss_n, 0);
               chk(cur_pos == exp_pos, "R3", "position order", cur_pos, exp_pos);
               if (cur_pos == 3) chk(ss_n == 4'b0111, "R3", "top line code", ss_n, 4'b0111);
               if (seen_xfer) chk(gap_cnt >= DIV, "R5", "gap cycles", gap_cnt, DIV);
               rises = 0; pre_cnt = 0;
            end
            if (sclk && !prev_sclk) begin
               rises++;
               mosi_byte = {mosi_byte[6:0], mosi};
               if (rises == 1) chk(pre_cnt >= HALF, "R4", "select setup", pre_cnt, HALF);
            end
            if (!sclk && rises == 0) pre_cnt++;
         end else begin
            if (!prev_hi) begin
               seen_xfer = 1; gap_cnt = 0;
               chk(rises == W, "R2", "rising edges", rises, W);
               chk(mosi_byte == M_TX, "R2", "mosi byte", mosi_byte, M_TX);
               chk(!sclk, "R4", "sclk low at release", sclk, 0);
            end
            gap_cnt++;
            if (sclk) chk(0, "R4", "sclk while deselected", 1, 0);
         end

         if (done) begin
            logic [7:0] exp;
            done_total++;
            if (prev_done) chk(0, "R6", "done width", 2, 1);
            chk(all_hi, "R6", "done at release", ss_n, 4'hF);
            exp = (cur_pos == 3) ? S_TX : (model_en ? model_byte : 8'hFF);
            chk(rx_data == exp, "R6", "rx byte", rx_data, exp);
            chk(match == (exp == M_KNOWN), cur_pos == 3 ? "R7" : "R8", "match flag", match, exp == M_KNOWN);
            if (cur_pos == 3) begin
               chk(slv_rx == M_TX, "R10", "slave rx", slv_rx, M_TX);
               chk(slv_match == 1'b1, "R10", "slave match", slv_match, 1);
            end
            if (model_en && cur_pos < 3) begin
               sweep_v++;
               model_byte = sweep_v[7:0];
            end
            if (want_sweep && !model_en && cur_pos == 3) begin
               model_en = 1; sweep_v = 0; model_byte = 8'h00;
            end
            exp_pos = (cur_pos + 1) % 4;
            last_rx = rx_data; last_match = match;
         end else begin
            chk(rx_data == last_rx && match == last_match, "R7", "hold between",
                {match, rx_data}, {last_match, last_rx});
         end
         prev_done = done;
      end
      prev_sclk = sclk;
      prev_hi = all_hi;
   end

   task automatic lone_xfer(input logic [7:0] b, input int nbits, output logic [7:0] got);
      got = 8'h00;
      t_ss = 1'b0; #10;
      for (int i = 0; i < nbits; i++) begin
         t_mosi = b[7-i]; #10;
         got = {got[6:0], t_miso};
         t_sclk = 1'b1; #10;
         t_sclk = 1'b0; #10;
      end
      t_ss = 1'b1; #10;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         tests++; fails++;
         $display("FAIL watchdog: actual %0d expected below 150000", cyc);
         finish_run();
      end
   end

   initial begin
      logic [7:0] got;
      int d0, f0;
      repeat (5) @(negedge clk);
      chk(ss_n == 4'hF, "R1", "ss_n in reset", ss_n, 4'hF);
      chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      chk(match == 1'b0, "R1", "match in reset", match, 0);
      chk(rx_data == 8'h00, "R1", "rx_data in reset", rx_data, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      chk(fall_total == 0 && done_total == 0, "R9", "idle while disabled", fall_total, 0);

      // Lone slave: good byte, bad byte, abort, stray clocks, recovery
      lone_xfer(S_KNOWN, 8, got);
      chk(t_rx == S_KNOWN, "R10", "lone rx", t_rx, S_KNOWN);
      chk(t_match == 1'b1, "R10", "lone match", t_match, 1);
      chk(got == S_TX, "R10", "lone miso byte", got, S_TX);
      lone_xfer(8'h3C, 8, got);
      chk(t_rx == 8'h3C && t_match == 1'b0, "R10", "lone mismatch", {t_match, t_rx}, 8'h3C);
      lone_xfer(8'hFF, 5, got);
      chk(t_rx == 8'h3C, "R11", "rx after abort", t_rx, 8'h3C);
      t_mosi = 1'b1;
      for (int i = 0; i < 11; i++) begin t_sclk = 1'b1; #10; t_sclk = 1'b0; #10; end
      chk(t_rx == 8'h3C, "R11", "rx after stray sclk", t_rx, 8'h3C);
      lone_xfer(S_KNOWN, 8, got);
      chk(t_rx == S_KNOWN && t_match == 1'b1, "R11", "rx after recovery", t_rx, S_KNOWN);
      chk(got == S_TX, "R11", "miso after recovery", got, S_TX);

      @(negedge clk); #1;
      enable = 1'b1;
      while (done_total < 24) @(negedge clk);
      want_sweep = 1;
      while (sweep_v < 256) @(negedge clk);

      // Drop enable just after a select line falls
      @(negedge clk);
      while (all_hi) @(negedge clk);
      #1;
      d0 = done_total; f0 = fall_total;
      enable = 1'b0;
      repeat (400) @(negedge clk);
      chk(done_total - d0 == 1, "R9", "in-flight finishes", done_total - d0, 1);
      chk(fall_total - f0 == 0, "R9", "no new exchange", fall_total - f0, 0);
      chk(ss_n == 4'hF && !sclk, "R9", "lines idle after stop", ss_n, 4'hF);
      finish_run();
   end

endmodule